// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block holds a small set of pending interrupt requests, one flip-flop per request source, and continuously selects the most urgent one with a priority encoder. A control sequencer sees a single active-low request line. It answers with a series of separate active-low strobes:

- one strobe freezes the selected source number in a code register and marks an interrupt as in service;
- one strobe places that source's vector address on the read bus;
- one strobe knocks down the serviced request flip-flop, so the next pending source reaches the encoder;
- one strobe empties the code register and ends the service period.

Two independent inhibit flags can hold the request line high. Software sets and clears the first flag with strobes. The second flag is set automatically when the sequencer asks for an overflow test and the top two write-bus bits disagree, and a strobe clears it.

Most request inputs are level sampled, because they arrive as counter-overflow pulses. A parameter can instead make a source edge sensitive; by default this applies to the keyboard source at the highest index. A general-reset strobe clears everything, and so does the synchronous reset.

Top module: `rupt_prio_ctrl`

## Requirements
- R1: While `rst` is high or `gen_rst_n` is low at a clock edge, all request cells, both inhibit flags, the code register and the in-service flag clear. Afterwards `irq_n` is 1, and a vector read returns the base address octal 2000.
- R2: A level-sensitive cell (indices 0 to 3 by default) becomes set at any clock edge where its `req_n` bit is 0. It stays set until it is knocked down or reset.
- R3: The edge-sensitive cell (index 4 by default) is set only at a clock edge where its `req_n` bit is 0 and was 1 at the previous edge. Holding the line low sets it once.
- R4: Lower index means higher priority. A latched code for cell i gives vector octal 2000 + 4*(i+1), so cells 0 to 4 map to octal 2004, 2010, 2014, 2020 and 2024.
- R5: A low `latch_n` at a clock edge stores the encoder output in the code register. While `vec_rd_n` is 0, `rbus` carries the vector of the stored code and `rbus_busy_n` is 0. Otherwise `rbus` is 0 and `rbus_busy_n` is 1.
- R6: A low `knock_n` clears only the cell named by the stored code, which lets the next pending cell be latched.
- R7: A low `clr_code_n` empties the code register, so a vector read returns octal 2000, and it ends the service period. When it meets `latch_n` in the same cycle, it wins.
- R8: `irq_n` is 0 exactly when some cell is set, no interrupt is in service (in service from a latch until a clear) and neither inhibit flag is set.
- R9: `inh_set_n` low sets the first inhibit flag and `inh_clr_n` low clears it. When both occur in the same cycle, set wins.
- R10: `ovf_test_n` low with `wb_ovf` different from `wb_sign` sets the second inhibit flag. With the two bits equal, the test leaves that flag unchanged. `inh1_clr_n` low clears it, and when it meets a setting test in the same cycle, the set wins.
- R11: When a new request for a cell arrives in the same cycle that the cell is knocked down, the cell stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | NCELL | Raw request lines, active low |
| latch_n | input | 1 | Latch encoder code, start service |
| vec_rd_n | input | 1 | Drive vector address onto read bus |
| knock_n | input | 1 | Clear the cell named by the code register |
| clr_code_n | input | 1 | Empty code register, end service |
| inh_set_n | input | 1 | Set first inhibit flag |
| inh_clr_n | input | 1 | Clear first inhibit flag |
| inh1_clr_n | input | 1 | Clear second inhibit flag |
| ovf_test_n | input | 1 | Test write bus for overflow |
| gen_rst_n | input | 1 | General reset strobe |
| wb_sign | input | 1 | Write-bus sign bit (bit 16) |
| wb_ovf | input | 1 | Write-bus overflow bit (bit 15) |
| irq_n | output | 1 | Interrupt request to sequencer, active low |
| rbus | output | DW | Read-bus contribution |
| rbus_busy_n | output | 1 | Low while this block drives the read bus |

## Verification
The bench uses the default parameters: five cells, a 16-bit bus, base octal 2000, step 4 and only cell 4 edge sensitive. With these values every vector from octal 2004 to 2024 can be reached. The single edge cell sits at the lowest priority, so level requests can hold it off while its input stays low. Random strobe mixes also drive latch, knock and clear into the same cycle, and set and clear onto each inhibit flag together. This reaches the same-cycle precedence rules that directed tests alone rarely produce.

// File: rtl/rpc_pkg.sv
`timescale 1ns/1ps
package rpc_pkg;

    localparam int RPC_DW        = 16;
    localparam int RPC_NCELL     = 5;
    localparam int RPC_VEC_BASE  = 'o2000;
    localparam int RPC_VEC_STEP  = 4;
    localparam int RPC_EDGE_MASK = 'b10000;

    // Internal active-high strobe bundle
    typedef struct packed {
        logic latch;
        logic vec_rd;
        logic knock;
        logic clr_code;
        logic inh_set;
        logic inh_clr;
        logic inh1_clr;
        logic ovf_test;
        logic grst;
    } strobe_t;

    // Overflow: the two top write-bus bits disagree
    function automatic logic wb_overflow(input logic sgn, input logic us);
        return sgn ^ us;
    endfunction

    // Vector address for a stored code; an empty register yields the base
    function automatic int vector_of(input logic valid, input int idx,
                                     input int base, input int step);
        return valid ? base + step * (idx + 1) : base;
    endfunction

endpackage

// File: rtl/rpc_cell_bank.sv
`timescale 1ns/1ps
module rpc_cell_bank #(
    parameter int NCELL     = rpc_pkg::RPC_NCELL,
    parameter int EDGE_MASK = rpc_pkg::RPC_EDGE_MASK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grst,
    input  logic [NCELL-1:0] req_n,
    input  logic [NCELL-1:0] knock_vec,
    output logic [NCELL-1:0] cells
);

    logic [NCELL-1:0] prev_q;
    logic [NCELL-1:0] set_vec;

    // Per-cell set detection: level or falling edge, chosen by parameter
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        if (EDGE_MASK[i]) begin : g_edge
            assign set_vec[i] = prev_q[i] & ~req_n[i];
        end else begin : g_level
            assign set_vec[i] = ~req_n[i];
        end

        // R6 / R11: a knock without a coinciding request clears the cell
        p_knock_clears_r6: assert property (@(posedge clk) disable iff (rst)
            (knock_vec[i] && !set_vec[i] && !grst) |=> !cells[i]);

        // R11: a coinciding request keeps the cell set
        p_set_beats_knock_r11: assert property (@(posedge clk) disable iff (rst)
            (set_vec[i] && !grst) |=> cells[i]);

        // R2 / R3: a cell only rises after its line was seen low
        p_rise_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(cells[i]) |-> ($past(req_n[i]) == 1'b0));
    end

    always_ff @(posedge clk) begin
        if (rst || grst) begin
            cells  <= '0;
            prev_q <= '1;
        end else begin
            cells  <= (cells & ~knock_vec) | set_vec;
            prev_q <= req_n;
        end
    end

    // R1: general reset empties every cell
    p_grst_clears_r1: assert property (@(posedge clk) disable iff (rst)
        grst |=> (cells == '0));

endmodule

// File: rtl/rpc_prio_enc.sv
`timescale 1ns/1ps
module rpc_prio_enc #(
    parameter int NCELL = rpc_pkg::RPC_NCELL,
    parameter int IDX_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
    input  logic [NCELL-1:0] cells,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the lowest-priority end so the lowest index wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NCELL - 1; i >= 0; i--) begin
            if (cells[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R4: reported index always names a set cell
    always_comb begin
        if (any) begin
            a_idx_is_set_r4: assert (cells[idx]);
        end
    end

endmodule

// File: rtl/rpc_ack_unit.sv
`timescale 1ns/1ps
module rpc_ack_unit
    import rpc_pkg::*;
#(
    parameter int NCELL    = RPC_NCELL,
    parameter int IDX_W    = (NCELL > 1) ? $clog2(NCELL) : 1,
    parameter int DW       = RPC_DW,
    parameter int VEC_BASE = RPC_VEC_BASE,
    parameter int VEC_STEP = RPC_VEC_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          stb,
    input  logic             wb_sign,
    input  logic             wb_ovf,
    input  logic             enc_any,
    input  logic [IDX_W-1:0] enc_idx,
    output logic [NCELL-1:0] knock_vec,
    output logic             irq_n,
    output logic [DW-1:0]    rbus,
    output logic             rbus_busy_n
);

    localparam int VEC_TOP = VEC_BASE + VEC_STEP * NCELL;

    logic             code_valid;
    logic [IDX_W-1:0] code_idx;
    logic             in_service;
    logic             inhint;
    logic             inhint1;

    // Knock-down targets only the cell held in the code register
    for (genvar i = 0; i < NCELL; i++) begin : g_knock
        assign knock_vec[i] = stb.knock && code_valid && (code_idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst || stb.grst) begin
            code_valid <= 1'b0;
            code_idx   <= '0;
            in_service <= 1'b0;
            inhint     <= 1'b0;
            inhint1    <= 1'b0;
        end else begin
            if (stb.clr_code) begin
                code_valid <= 1'b0;
                code_idx   <= '0;
                in_service <= 1'b0;
            end else if (stb.latch) begin
                code_valid <= enc_any;
                code_idx   <= enc_idx;
                in_service <= 1'b1;
            end

            if (stb.inh_set)
                inhint <= 1'b1;
            else if (stb.inh_clr)
                inhint <= 1'b0;

            if (stb.ovf_test && wb_overflow(wb_sign, wb_ovf))
                inhint1 <= 1'b1;
            else if (stb.inh1_clr)
                inhint1 <= 1'b0;
        end
    end

    assign irq_n       = ~(enc_any & ~in_service & ~inhint & ~inhint1);
    assign rbus        = stb.vec_rd
                       ? DW'(vector_of(code_valid, int'(code_idx), VEC_BASE, VEC_STEP))
                       : '0;
    assign rbus_busy_n = ~stb.vec_rd;

    // R8: after a latch without clear, the request line is released
    p_latch_quiets_r8: assert property (@(posedge clk) disable iff (rst)
        (stb.latch && !stb.clr_code && !stb.grst) |=> irq_n);

    // R7: clear empties the register and ends service
    p_clear_code_r7: assert property (@(posedge clk) disable iff (rst)
        (stb.clr_code && !stb.grst) |=> (!code_valid && !in_service));

    // R9: set strobe always leaves the first flag set
    p_inh_set_r9: assert property (@(posedge clk) disable iff (rst)
        (stb.inh_set && !stb.grst) |=> inhint);

    // R10: overflow test with disagreeing bits sets the second flag
    p_ovf_sets_r10: assert property (@(posedge clk) disable iff (rst)
        (stb.ovf_test && (wb_sign != wb_ovf) && !stb.grst) |=> inhint1);

    // R10: equal bits and no clear leave the second flag unchanged
    p_ovf_equal_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!stb.grst && !stb.inh1_clr && !(stb.ovf_test && (wb_sign != wb_ovf)))
        |=> $stable(inhint1));

    // R4 / R5: a driven vector lies inside the table window
    p_vec_window_r4: assert property (@(posedge clk) disable iff (rst)
        !rbus_busy_n |-> ((int'(rbus) >= VEC_BASE) && (int'(rbus) <= VEC_TOP)));

    // R5: an idle bus contribution is all zero
    p_bus_idle_r5: assert property (@(posedge clk) disable iff (rst)
        rbus_busy_n |-> (rbus == '0));

endmodule

// File: rtl/rupt_prio_ctrl.sv
`timescale 1ns/1ps
module rupt_prio_ctrl
    import rpc_pkg::*;
#(
    parameter int NCELL     = RPC_NCELL,
    parameter int DW        = RPC_DW,
    parameter int VEC_BASE  = RPC_VEC_BASE,
    parameter int VEC_STEP  = RPC_VEC_STEP,
    parameter int EDGE_MASK = RPC_EDGE_MASK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCELL-1:0] req_n,
    input  logic             latch_n,
    input  logic             vec_rd_n,
    input  logic             knock_n,
    input  logic             clr_code_n,
    input  logic             inh_set_n,
    input  logic             inh_clr_n,
    input  logic             inh1_clr_n,
    input  logic             ovf_test_n,
    input  logic             gen_rst_n,
    input  logic             wb_sign,
    input  logic             wb_ovf,
    output logic             irq_n,
    output logic [DW-1:0]    rbus,
    output logic             rbus_busy_n
);

    localparam int IDX_W = (NCELL > 1) ? $clog2(NCELL) : 1;

    strobe_t          stb;
    logic [NCELL-1:0] cells;
    logic [NCELL-1:0] knock_vec;
    logic             enc_any;
    logic [IDX_W-1:0] enc_idx;

    always_comb begin
        stb.latch    = ~latch_n;
        stb.vec_rd   = ~vec_rd_n;
        stb.knock    = ~knock_n;
        stb.clr_code = ~clr_code_n;
        stb.inh_set  = ~inh_set_n;
        stb.inh_clr  = ~inh_clr_n;
        stb.inh1_clr = ~inh1_clr_n;
        stb.ovf_test = ~ovf_test_n;
        stb.grst     = ~gen_rst_n;
    end

    rpc_cell_bank #(
        .NCELL     (NCELL),
        .EDGE_MASK (EDGE_MASK)
    ) u_cells (
        .clk       (clk),
        .rst       (rst),
        .grst      (stb.grst),
        .req_n     (req_n),
        .knock_vec (knock_vec),
        .cells     (cells)
    );

    rpc_prio_enc #(
        .NCELL (NCELL),
        .IDX_W (IDX_W)
    ) u_enc (
        .cells (cells),
        .any   (enc_any),
        .idx   (enc_idx)
    );

    rpc_ack_unit #(
        .NCELL    (NCELL),
        .IDX_W    (IDX_W),
        .DW       (DW),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_ack (
        .clk         (clk),
        .rst         (rst),
        .stb         (stb),
        .wb_sign     (wb_sign),
        .wb_ovf      (wb_ovf),
        .enc_any     (enc_any),
        .enc_idx     (enc_idx),
        .knock_vec   (knock_vec),
        .irq_n       (irq_n),
        .rbus        (rbus),
        .rbus_busy_n (rbus_busy_n)
    );

    // R1: general reset releases the request line
    p_grst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !gen_rst_n |=> irq_n);

endmodule

// File: tb/rupt_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module rupt_prio_ctrl_tb_top;

    localparam int NC = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] req_n = '1;
    logic latch_n = 1, vec_rd_n = 1, knock_n = 1, clr_code_n = 1;
    logic inh_set_n = 1, inh_clr_n = 1, inh1_clr_n = 1, ovf_test_n = 1;
    logic gen_rst_n = 1, wb_sign = 0, wb_ovf = 0;
    logic          irq_n;
    logic [15:0]   rbus;
    logic          rbus_busy_n;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model of the required behaviour
    logic [NC-1:0] m_cells = '0;
    logic [NC-1:0] m_prev  = '1;
    logic m_valid = 0, m_svc = 0, m_inh = 0, m_inh1 = 0;
    int   m_idx = 0;

    always #2.5 clk = ~clk;

    rupt_prio_ctrl dut_i (
        .clk(clk), .rst(rst), .req_n(req_n), .latch_n(latch_n),
        .vec_rd_n(vec_rd_n), .knock_n(knock_n), .clr_code_n(clr_code_n),
        .inh_set_n(inh_set_n), .inh_clr_n(inh_clr_n), .inh1_clr_n(inh1_clr_n),
        .ovf_test_n(ovf_test_n), .gen_rst_n(gen_rst_n), .wb_sign(wb_sign),
        .wb_ovf(wb_ovf), .irq_n(irq_n), .rbus(rbus), .rbus_busy_n(rbus_busy_n)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0o expected %0o (octal) at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int lowest(input logic [NC-1:0] c);
        for (int i = NC - 1; i >= 0; i--) if (c[i]) lowest = i;
        if (c == '0) lowest = 0;
    endfunction

    function automatic logic exp_irq();
        return !((m_cells != '0) && !m_svc && !m_inh && !m_inh1);
    endfunction

    function automatic logic [15:0] exp_bus(input logic rd_n);
        if (rd_n) return 16'h0;
        return m_valid ? 16'(16'o2000 + 4 * (m_idx + 1)) : 16'o2000;
    endfunction

    task automatic model_step();
        logic [NC-1:0] setv, kn;
        if (rst || !gen_rst_n) begin
            m_cells = '0; m_prev = '1; m_valid = 0; m_idx = 0;
            m_svc = 0; m_inh = 0; m_inh1 = 0;
            return;
        end
        for (int i = 0; i < NC; i++)
            setv[i] = (i == 4) ? (m_prev[i] && !req_n[i]) : !req_n[i];
        kn = '0;
        if (!knock_n && m_valid) kn[m_idx] = 1'b1;
        if (!clr_code_n) begin
            m_valid = 0; m_idx = 0; m_svc = 0;
        end else if (!latch_n) begin
            m_valid = (m_cells != '0); m_idx = lowest(m_cells); m_svc = 1;
        end
        if (!inh_set_n) m_inh = 1; else if (!inh_clr_n) m_inh = 0;
        if (!ovf_test_n && (wb_sign != wb_ovf)) m_inh1 = 1;
        else if (!inh1_clr_n) m_inh1 = 0;
        m_cells = (m_cells & ~kn) | setv;
        m_prev  = req_n;
    endtask

    // Called at a falling edge with inputs set; compares, clocks, updates model
    task automatic tick();
        #1;
        chk(32'(irq_n), 32'(exp_irq()), "R8 irq_n vs model");
        chk(32'(rbus), 32'(exp_bus(vec_rd_n)), "R5 rbus vs model");
        chk(32'(rbus_busy_n), 32'(vec_rd_n), "R5 busy_n vs model");
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        req_n = '1; latch_n = 1; vec_rd_n = 1; knock_n = 1; clr_code_n = 1;
        inh_set_n = 1; inh_clr_n = 1; inh1_clr_n = 1; ovf_test_n = 1;
        gen_rst_n = 1; wb_sign = 0; wb_ovf = 0;
    endtask

    task automatic read_vec(input logic [15:0] exp, input string tag);
        vec_rd_n = 0;
        #0.5;
        chk(32'(rbus), 32'(exp), tag);
        chk(32'(rbus_busy_n), 32'd0, tag);
        vec_rd_n = 1;
        #0.2;
    endtask

    task automatic pulse_latch(); idle(); latch_n = 0; tick(); idle(); endtask
    task automatic pulse_knock(); idle(); knock_n = 0; tick(); idle(); endtask
    task automatic pulse_clear(); idle(); clr_code_n = 0; tick(); idle(); endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd4711);
        @(negedge clk);
        idle(); rst = 1; tick(); tick(); rst = 0;

        // R1: reset state
        #0.5;
        chk(32'(irq_n), 32'd1, "R1 irq_n after reset");
        chk(32'(rbus), 32'd0, "R5 idle bus zero");
        chk(32'(rbus_busy_n), 32'd1, "R5 idle busy_n high");
        read_vec(16'o2000, "R1 empty code reads base");

        // R2: level cell 2 stays set after line returns high
        idle(); req_n[2] = 0; tick(); idle(); tick();
        #0.5; chk(32'(irq_n), 32'd0, "R2 level cell held");
        pulse_latch();
        read_vec(16'o2014, "R4 cell 2 vector");
        #0.2; chk(32'(irq_n), 32'd1, "R8 quiet while in service");
        pulse_knock(); pulse_clear();
        #0.5; chk(32'(irq_n), 32'd1, "R6 knocked cell gone");
        read_vec(16'o2000, "R7 clear empties code");

        // R4 / R6: priority between cells 1 and 3
        idle(); req_n[1] = 0; req_n[3] = 0; tick(); idle();
        pulse_latch();
        read_vec(16'o2010, "R4 cell 1 beats cell 3");
        pulse_knock(); pulse_latch();
        read_vec(16'o2020, "R6 next cell after knock");
        pulse_knock(); pulse_clear();

        // R3: edge cell sets once while held low
        idle(); req_n[4] = 0; tick(); tick(); tick();
        latch_n = 0; tick(); latch_n = 1;
        read_vec(16'o2024, "R3 edge cell vector");
        knock_n = 0; tick(); knock_n = 1; tick();
        clr_code_n = 0; tick(); clr_code_n = 1; tick();
        #0.5; chk(32'(irq_n), 32'd1, "R3 held low no re-set");
        req_n[4] = 1; tick(); req_n[4] = 0; tick();
        #0.5; chk(32'(irq_n), 32'd0, "R3 new falling edge sets");
        pulse_latch(); pulse_knock(); pulse_clear();

        // R9 / R10: inhibit flags
        idle(); req_n[0] = 0; tick(); idle();
        inh_set_n = 0; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd1, "R9 inhibit set");
        inh_set_n = 0; inh_clr_n = 0; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd1, "R9 set wins over clear");
        inh_clr_n = 0; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd0, "R9 inhibit cleared");
        ovf_test_n = 0; wb_sign = 1; wb_ovf = 1; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd0, "R10 equal bits no inhibit");
        ovf_test_n = 0; wb_sign = 0; wb_ovf = 1; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd1, "R10 positive overflow inhibits");
        inh1_clr_n = 0; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd0, "R10 second flag cleared");
        ovf_test_n = 0; inh1_clr_n = 0; wb_sign = 1; wb_ovf = 0; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd1, "R10 negative overflow beats clear");
        inh1_clr_n = 0; tick(); idle();

        // R11: request coinciding with knock keeps the cell
        pulse_latch();
        idle(); knock_n = 0; req_n[0] = 0; tick(); idle();
        pulse_clear();
        #0.5; chk(32'(irq_n), 32'd0, "R11 cell survives knock");
        pulse_latch();
        read_vec(16'o2004, "R11 cell 0 still pending");
        pulse_knock(); pulse_clear();

        // R1: general reset strobe
        idle(); req_n[1] = 0; inh_set_n = 0; tick(); idle();
        gen_rst_n = 0; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd1, "R1 general reset clears cells");
        req_n[2] = 0; tick(); idle();
        #0.5; chk(32'(irq_n), 32'd0, "R1 general reset clears inhibit");
        pulse_latch();
        read_vec(16'o2014, "R1 cell 1 was cleared");
        pulse_knock(); pulse_clear();

        // Constrained random mix checked against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NC; i++) req_n[i] = ($urandom_range(5) != 0);
            latch_n    = ($urandom_range(7) != 0);
            vec_rd_n   = ($urandom_range(3) != 0);
            knock_n    = ($urandom_range(7) != 0);
            clr_code_n = ($urandom_range(9) != 0);
            inh_set_n  = ($urandom_range(11) != 0);
            inh_clr_n  = ($urandom_range(5) != 0);
            inh1_clr_n = ($urandom_range(5) != 0);
            ovf_test_n = ($urandom_range(9) != 0);
            gen_rst_n  = ($urandom_range(199) != 0);
            wb_sign    = 1'($urandom_range(1));
            wb_ovf     = 1'($urandom_range(1));
            tick();
        end
        idle(); tick();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule